// File: doc/BRIEF.md
# Barrel-Scheduled Peripheral Processor Array

This block holds ten small 12-bit processor contexts that share one execution stage. A rotating slot counter hands that stage to one context per clock cycle, in the fixed order 0 to 9. Each context has its own private program memory, program counter and accumulator, and it completes exactly one instruction per turn. The instruction set is small: load immediate, add immediate, load, add, subtract, AND, store, jump, channel write, channel read and channel release.

Twelve I/O channels are shared by all contexts. Writing to a channel makes the writing context the channel's owner. Any other context that tries to write to an owned channel waits: its program counter stays put and it retries on its next turn, while the rest of the rotation carries on. Reading a channel needs no ownership, so one context can read a channel that another context is writing. Ownership ends when the owner issues a release, or when the owner's hold input is raised.

A memory load port fills context memories, normally while the contexts are held. Each context's hold input parks that context at address 0 with a cleared accumulator.

Top module: `pp_barrel`

## Requirements
- R1: A slot counter starts at 0 on the first clock edge after reset and steps 0,1,…,NCTX-1,0,… by one each edge. Context i runs exactly one instruction on each edge where the slot equals i, and no other context changes state on that edge.
- R2: Each context owns a private memory of 2**ADDR_W words of 12 bits (ADDR_W=12 gives 4096 words). The load port writes word `ld_data` at `ld_addr` of context `ld_ctx` on an edge where `ld_we` is high, and this write takes priority over a store.
- R3: An instruction word holds the opcode in bits 11:6 and the operand d in bits 5:0. The opcodes are NOP=0, LDN=1, ADN=2, LDM=3, ADM=4, SBM=5, ANM=6, STM=7, JMP=8, OUT=9, INP=10 and REL=11. Any other opcode acts as NOP. One-word instructions advance the PC by 1.
- R4: LDM, ADM, SBM, ANM, STM and JMP take two words. The address is the low ADDR_W bits of the 18-bit value {d, next word}. JMP loads that address into the PC, and the other two-word instructions advance the PC by 2.
- R5: Arithmetic works modulo 4096. LDN loads d zero-extended, ADN adds d, LDM loads the memory word, ADM adds it, SBM subtracts it, ANM ANDs it, and STM stores the accumulator.
- R6: OUT d writes the accumulator to channel d when the channel is free or already owned by the same context. The context then becomes the owner, `chan_busy[d]` goes high, `chan_data` shows the value, and `chan_stb[d]` pulses for one cycle after the executing edge.
- R7: OUT to a channel owned by another context has no effect. The PC stays unchanged, the context retries on its next turn, and the other contexts keep running.
- R8: INP d loads the last value written to channel d into the accumulator, without ownership and even while another context owns the channel.
- R9: REL d from the owner frees channel d. REL d from any other context is ignored.
- R10: While `ctx_hold[i]` is high, context i does not run, its PC and accumulator are 0, and every channel it owns is freed on the next edge.
- R11: OUT, INP or REL with d at or above NCHAN (12) has no effect other than advancing the PC by 1.
- R12: Reset clears all channel ownership, strobes and channel data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctx_hold | input | NCTX | Per-context hold: park, clear and free channels |
| ld_we | input | 1 | Memory load write enable |
| ld_ctx | input | CTX_W | Context whose memory is loaded |
| ld_addr | input | ADDR_W | Load word address |
| ld_data | input | 12 | Load word value |
| chan_stb | output | NCHAN | One-cycle pulse per channel write |
| chan_data | output | NCHAN*12 | Last value written to each channel, channel c at bits 12c+11:12c |
| chan_busy | output | NCHAN | Channel currently owned |

## Verification
Context i runs its k-th instruction on edge number i+10k, counting edge 0 as the first edge after reset and hold are released together. A channel write therefore shows on `chan_stb`, `chan_data` and `chan_busy` one cycle after that edge. Ownership changes from REL or from hold show on `chan_busy` one cycle after the edge that performs them. The bench counts edges from the release, and every expected write carries the count at which it must appear. A monitor samples on the falling edge and compares each strobe against the head of the expected queue, checking channel, value and count. Busy flags are sampled at fixed counts just before and after each ownership change.

// File: rtl/pp_barrel_pkg.sv
package pp_barrel_pkg;

    localparam int WORD_W = 12;
    localparam int OP_W   = 6;
    localparam int ARG_W  = 6;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [OP_W-1:0] {
        OP_NOP = 6'd0,
        OP_LDN = 6'd1,
        OP_ADN = 6'd2,
        OP_LDM = 6'd3,
        OP_ADM = 6'd4,
        OP_SBM = 6'd5,
        OP_ANM = 6'd6,
        OP_STM = 6'd7,
        OP_JMP = 6'd8,
        OP_OUT = 6'd9,
        OP_INP = 6'd10,
        OP_REL = 6'd11
    } op_e;

    typedef struct packed {
        logic [OP_W-1:0]  op;
        logic [ARG_W-1:0] arg;
    } instr_t;

    typedef enum logic [1:0] {
        CH_NONE,
        CH_WRITE,
        CH_FREE
    } chop_e;

    function automatic word_t widen_arg(logic [ARG_W-1:0] a);
        return WORD_W'(a);
    endfunction

    function automatic logic arg_is_channel(logic [ARG_W-1:0] a, int nchan);
        return 32'(a) < nchan;
    endfunction

endpackage

// File: rtl/pp_ctx_mem.sv
module pp_ctx_mem
    import pp_barrel_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  word_t             wdata,
    input  logic [ADDR_W-1:0] ra_a,
    input  logic [ADDR_W-1:0] ra_b,
    input  logic [ADDR_W-1:0] ra_c,
    output word_t             rd_a,
    output word_t             rd_b,
    output word_t             rd_c
);
    localparam int DEPTH = 2 ** ADDR_W;

    word_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rd_a = mem[ra_a];
    assign rd_b = mem[ra_b];
    assign rd_c = mem[ra_c];

endmodule

// File: rtl/pp_exec.sv
module pp_exec
    import pp_barrel_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int NCHAN  = 12
) (
    input  logic [ADDR_W-1:0]        pc,
    input  word_t                    acc,
    input  word_t                    w0,
    input  word_t                    w1,
    input  word_t                    dmem,
    input  word_t                    chan_val,
    input  logic                     chan_ok,
    output logic [ADDR_W-1:0]        dptr,
    output logic [ADDR_W-1:0]        pc_next,
    output word_t                    acc_next,
    output logic                     mem_we,
    output chop_e                    ch_op,
    output logic [$clog2(NCHAN)-1:0] ch_sel,
    output logic                     stall
);
    localparam int CH_W = $clog2(NCHAN);

    instr_t ins;
    logic   ch_valid;

    assign ins      = instr_t'(w0);
    assign dptr     = ADDR_W'({ins.arg, w1});
    assign ch_valid = arg_is_channel(ins.arg, NCHAN);
    assign ch_sel   = CH_W'(ins.arg);

    always_comb begin
        pc_next  = pc + ADDR_W'(1);
        acc_next = acc;
        mem_we   = 1'b0;
        ch_op    = CH_NONE;
        stall    = 1'b0;
        case (ins.op)
            OP_LDN: acc_next = widen_arg(ins.arg);
            OP_ADN: acc_next = acc + widen_arg(ins.arg);
            OP_LDM: begin acc_next = dmem;        pc_next = pc + ADDR_W'(2); end
            OP_ADM: begin acc_next = acc + dmem;  pc_next = pc + ADDR_W'(2); end
            OP_SBM: begin acc_next = acc - dmem;  pc_next = pc + ADDR_W'(2); end
            OP_ANM: begin acc_next = acc & dmem;  pc_next = pc + ADDR_W'(2); end
            OP_STM: begin mem_we = 1'b1;          pc_next = pc + ADDR_W'(2); end
            OP_JMP: pc_next = dptr;
            OP_OUT: begin
                if (ch_valid) begin
                    ch_op = CH_WRITE;
                    if (!chan_ok) begin
                        stall   = 1'b1;
                        pc_next = pc;
                    end
                end
            end
            OP_INP: if (ch_valid) acc_next = chan_val;
            OP_REL: if (ch_valid) ch_op = CH_FREE;
            default: ;
        endcase
    end

endmodule

// File: rtl/pp_chan_arb.sv
module pp_chan_arb
    import pp_barrel_pkg::*;
#(
    parameter int NCTX  = 10,
    parameter int NCHAN = 12
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NCTX-1:0]            hold,
    input  logic                       fire,
    input  logic [$clog2(NCTX)-1:0]    ctx,
    input  chop_e                      op,
    input  logic [$clog2(NCHAN)-1:0]   sel,
    input  word_t                      wdata,
    output logic                       grant,
    output word_t                      rdata,
    output logic [NCHAN-1:0]           busy,
    output logic [NCHAN-1:0]           stb,
    output logic [NCHAN*WORD_W-1:0]    data_flat
);
    localparam int CTX_W = $clog2(NCTX);

    logic [NCHAN-1:0] busy_q;
    logic [NCHAN-1:0] stb_q;
    logic [CTX_W-1:0] owner_q [NCHAN];
    word_t            data_q  [NCHAN];
    logic [NCHAN-1:0] hit;
    logic             sel_ok;

    assign sel_ok = 32'(sel) < NCHAN;
    assign grant  = sel_ok && (!busy_q[sel] || owner_q[sel] == ctx);
    assign rdata  = sel_ok ? data_q[sel] : '0;

    always_comb begin
        for (int c = 0; c < NCHAN; c++) begin
            hit[c] = fire && (32'(sel) == c);
            data_flat[c*WORD_W +: WORD_W] = data_q[c];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= '0;
            stb_q  <= '0;
            for (int c = 0; c < NCHAN; c++) begin
                owner_q[c] <= '0;
                data_q[c]  <= '0;
            end
        end else begin
            for (int c = 0; c < NCHAN; c++) begin
                stb_q[c] <= 1'b0;
                if (busy_q[c] && hold[owner_q[c]]) begin
                    busy_q[c] <= 1'b0;
                end else if (hit[c] && op == CH_FREE && busy_q[c] && owner_q[c] == ctx) begin
                    busy_q[c] <= 1'b0;
                end else if (hit[c] && op == CH_WRITE && grant) begin
                    busy_q[c]  <= 1'b1;
                    owner_q[c] <= ctx;
                    data_q[c]  <= wdata;
                    stb_q[c]   <= 1'b1;
                end
            end
        end
    end

    assign busy = busy_q;
    assign stb  = stb_q;

    // R1: a single execution slot means at most one channel write per cycle
    assert_single_strobe_R1: assert property (@(posedge clk) disable iff (rst)
        $onehot0(stb_q))
        else $error("more than one channel strobe in a cycle");

    for (genvar c = 0; c < NCHAN; c++) begin : g_chk
        // R7: an owned channel keeps its owner until it is freed
        assert_owner_kept_R7: assert property (@(posedge clk) disable iff (rst)
            (busy_q[c] && $past(busy_q[c])) |-> owner_q[c] == $past(owner_q[c]))
            else $error("channel %0d changed owner while busy", c);
        // R6: a strobe only appears on an owned channel
        assert_strobe_owned_R6: assert property (@(posedge clk) disable iff (rst)
            stb_q[c] |-> busy_q[c])
            else $error("channel %0d strobed without owner", c);
        // R10: hold of the owner frees the channel
        assert_hold_frees_R10: assert property (@(posedge clk) disable iff (rst)
            (busy_q[c] && hold[owner_q[c]]) |=> !busy_q[c])
            else $error("channel %0d not freed on owner hold", c);
    end

endmodule

// File: rtl/pp_barrel.sv
module pp_barrel
    import pp_barrel_pkg::*;
#(
    parameter int NCTX   = 10,
    parameter int NCHAN  = 12,
    parameter int ADDR_W = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NCTX-1:0]            ctx_hold,
    input  logic                       ld_we,
    input  logic [$clog2(NCTX)-1:0]    ld_ctx,
    input  logic [ADDR_W-1:0]          ld_addr,
    input  logic [WORD_W-1:0]          ld_data,
    output logic [NCHAN-1:0]           chan_stb,
    output logic [NCHAN*WORD_W-1:0]    chan_data,
    output logic [NCHAN-1:0]           chan_busy
);
    localparam int CTX_W = $clog2(NCTX);
    localparam int CH_W  = $clog2(NCHAN);

    logic [CTX_W-1:0]  slot_q;
    logic [ADDR_W-1:0] pc_q  [NCTX];
    word_t             acc_q [NCTX];

    word_t w0_v [NCTX];
    word_t w1_v [NCTX];
    word_t dm_v [NCTX];

    logic              active;
    logic [ADDR_W-1:0] cur_pc;
    word_t             cur_acc;
    word_t             cur_w0, cur_w1, cur_dm;

    logic [ADDR_W-1:0] dptr, pc_next;
    word_t             acc_next;
    logic              exec_we;
    chop_e             ch_op;
    logic [CH_W-1:0]   ch_sel;
    logic              stall;
    logic              chan_ok;
    word_t             chan_val;

    assign active  = !rst && !ctx_hold[slot_q];
    assign cur_pc  = pc_q[slot_q];
    assign cur_acc = acc_q[slot_q];
    assign cur_w0  = w0_v[slot_q];
    assign cur_w1  = w1_v[slot_q];
    assign cur_dm  = dm_v[slot_q];

    for (genvar i = 0; i < NCTX; i++) begin : g_ctx
        logic              ld_hit, we;
        logic [ADDR_W-1:0] waddr;
        word_t             wdata;

        assign ld_hit = ld_we && ld_ctx == CTX_W'(i);
        assign we     = ld_hit || (exec_we && active && slot_q == CTX_W'(i));
        assign waddr  = ld_hit ? ld_addr : dptr;
        assign wdata  = ld_hit ? ld_data : cur_acc;

        pp_ctx_mem #(.ADDR_W(ADDR_W)) u_mem (
            .clk   (clk),
            .we    (we),
            .waddr (waddr),
            .wdata (wdata),
            .ra_a  (pc_q[i]),
            .ra_b  (pc_q[i] + ADDR_W'(1)),
            .ra_c  (dptr),
            .rd_a  (w0_v[i]),
            .rd_b  (w1_v[i]),
            .rd_c  (dm_v[i])
        );

        // R1: a context outside its slot keeps its program counter
        assert_idle_ctx_R1: assert property (@(posedge clk) disable iff (rst)
            (slot_q != CTX_W'(i) && !ctx_hold[i]) |=> pc_q[i] == $past(pc_q[i]))
            else $error("context %0d advanced outside its slot", i);
    end

    pp_exec #(.ADDR_W(ADDR_W), .NCHAN(NCHAN)) u_exec (
        .pc       (cur_pc),
        .acc      (cur_acc),
        .w0       (cur_w0),
        .w1       (cur_w1),
        .dmem     (cur_dm),
        .chan_val (chan_val),
        .chan_ok  (chan_ok),
        .dptr     (dptr),
        .pc_next  (pc_next),
        .acc_next (acc_next),
        .mem_we   (exec_we),
        .ch_op    (ch_op),
        .ch_sel   (ch_sel),
        .stall    (stall)
    );

    pp_chan_arb #(.NCTX(NCTX), .NCHAN(NCHAN)) u_arb (
        .clk       (clk),
        .rst       (rst),
        .hold      (ctx_hold),
        .fire      (active && ch_op != CH_NONE),
        .ctx       (slot_q),
        .op        (ch_op),
        .sel       (ch_sel),
        .wdata     (cur_acc),
        .grant     (chan_ok),
        .rdata     (chan_val),
        .busy      (chan_busy),
        .stb       (chan_stb),
        .data_flat (chan_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q <= '0;
            for (int i = 0; i < NCTX; i++) begin
                pc_q[i]  <= '0;
                acc_q[i] <= '0;
            end
        end else begin
            slot_q <= (slot_q == CTX_W'(NCTX - 1)) ? '0 : slot_q + CTX_W'(1);
            for (int i = 0; i < NCTX; i++) begin
                if (ctx_hold[i]) begin
                    pc_q[i]  <= '0;
                    acc_q[i] <= '0;
                end else if (active && slot_q == CTX_W'(i)) begin
                    pc_q[i]  <= pc_next;
                    acc_q[i] <= acc_next;
                end
            end
        end
    end

    // R7: a context refused a channel keeps its program counter for a retry
    assert_wait_keeps_pc_R7: assert property (@(posedge clk) disable iff (rst)
        (active && stall) |=> pc_q[$past(slot_q)] == $past(cur_pc))
        else $error("waiting context moved its program counter");

    // R1: the slot index never leaves the context range
    assert_slot_range_R1: assert property (@(posedge clk) disable iff (rst)
        32'(slot_q) < NCTX)
        else $error("slot out of range");

endmodule

// File: tb/pp_barrel_bench.sv
`timescale 1ns/1ps
module pp_barrel_bench;
    localparam int NCTX = 10, NCHAN = 12, AW = 8;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic [NCTX-1:0]      ctx_hold = '1;
    logic                 ld_we = 1'b0;
    logic [3:0]           ld_ctx = '0;
    logic [AW-1:0]        ld_addr = '0;
    logic [11:0]          ld_data = '0;
    logic [NCHAN-1:0]     chan_stb;
    logic [NCHAN*12-1:0]  chan_data;
    logic [NCHAN-1:0]     chan_busy;

    int errors = 0, checks = 0, ncyc = 0;
    bit running = 0, done = 0;

    typedef struct { int ch; int data; int n; string tag; } exp_t;
    exp_t q[$];

    always #2.5 clk = ~clk;

    pp_barrel #(.NCTX(NCTX), .NCHAN(NCHAN), .ADDR_W(AW)) u_pp_barrel (
        .clk(clk), .rst(rst), .ctx_hold(ctx_hold), .ld_we(ld_we), .ld_ctx(ld_ctx),
        .ld_addr(ld_addr), .ld_data(ld_data), .chan_stb(chan_stb),
        .chan_data(chan_data), .chan_busy(chan_busy));

    always @(posedge clk) if (running) ncyc <= ncyc + 1;

    function automatic logic [11:0] mk(int op, int arg);
        return {6'(op), 6'(arg)};
    endfunction

    task automatic put(int c, int a, logic [11:0] d);
        @(negedge clk);
        ld_we = 1'b1; ld_ctx = 4'(c); ld_addr = AW'(a); ld_data = d;
    endtask

    task automatic expect_out(int ch, int data, int n, string tag);
        exp_t e;
        e.ch = ch; e.data = data; e.n = n; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (n=%0d)", tag, act, exp, ncyc);
        end
    endtask

    // monitor: each strobe must match the head of the expected queue
    always @(negedge clk) begin
        if (running && chan_stb != '0) begin
            exp_t e;
            int ch;
            ch = -1;
            for (int c = 0; c < NCHAN; c++) if (chan_stb[c]) ch = c;
            if (q.size() == 0) begin
                chk(0, "R11 unexpected channel write", ch, -1);
            end else begin
                e = q.pop_front();
                chk(ch == e.ch, {e.tag, " channel"}, ch, e.ch);
                chk(int'(chan_data[ch*12 +: 12]) == e.data, {e.tag, " data"},
                    int'(chan_data[ch*12 +: 12]), e.data);
                chk(ncyc == e.n, {e.tag, " R1 cycle"}, ncyc, e.n);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(chan_busy == '0, "R12 reset busy", int'(chan_busy), 0);
        chk(chan_stb == '0, "R12 reset strobe", int'(chan_stb), 0);
        chk(chan_data == '0, "R12 reset data", int'(chan_data[11:0]), 0);
        // ctx0: owner writes twice then releases
        put(0,0,mk(1,5)); put(0,1,mk(2,3)); put(0,2,mk(9,2)); put(0,3,mk(1,9));
        put(0,4,mk(9,2)); put(0,5,mk(11,2)); put(0,6,mk(8,0)); put(0,7,12'd6);
        // ctx1: blocked on ch2 until ctx0 releases
        put(1,0,mk(1,7)); put(1,1,0); put(1,2,0); put(1,3,0); put(1,4,mk(9,2));
        put(1,5,mk(11,2)); put(1,6,mk(8,0)); put(1,7,12'd6);
        // ctx2: memory arithmetic
        put(2,0,mk(3,63)); put(2,1,12'h040); put(2,2,mk(4,0)); put(2,3,12'h041);
        put(2,4,mk(5,0)); put(2,5,12'h042); put(2,6,mk(6,0)); put(2,7,12'h043);
        put(2,8,mk(7,0)); put(2,9,12'h044); put(2,10,mk(1,0)); put(2,11,mk(3,0));
        put(2,12,12'h044); put(2,13,mk(9,5)); put(2,14,mk(8,0)); put(2,15,12'd14);
        put(2,64,12'd100); put(2,65,12'd30); put(2,66,12'd200); put(2,67,12'h0F0);
        // ctx3: read an owned channel, non-owner release
        put(3,0,0); put(3,1,0); put(3,2,mk(10,2)); put(3,3,mk(9,7));
        put(3,4,mk(11,2)); put(3,5,mk(11,7)); put(3,6,mk(8,0)); put(3,7,12'd6);
        // ctx4: out-of-range channel
        put(4,0,mk(1,1)); put(4,1,mk(9,20)); put(4,2,mk(9,4)); put(4,3,mk(8,0)); put(4,4,12'd3);
        // ctx5 / ctx6: hold frees channel 9
        put(5,0,mk(1,3)); put(5,1,mk(9,9)); put(5,2,mk(8,0)); put(5,3,12'd2);
        put(6,0,mk(1,6)); put(6,1,mk(9,9)); put(6,2,mk(8,0)); put(6,3,12'd2);
        // ctx7: jump
        put(7,0,mk(8,0)); put(7,1,12'h010); put(7,16,mk(1,42)); put(7,17,mk(9,0));
        put(7,18,mk(8,0)); put(7,19,12'h012);
        // ctx8: add wrap
        put(8,0,mk(3,0)); put(8,1,12'h040); put(8,2,mk(2,2)); put(8,3,mk(9,1));
        put(8,4,mk(8,0)); put(8,5,12'd4); put(8,64,12'hFFF);
        // ctx9: idle loop
        put(9,0,mk(8,0)); put(9,1,12'd0);
        @(negedge clk);
        ld_we = 1'b0;

        expect_out(9, 3,     16, "R6 ctx5 claim");
        expect_out(2, 8,     21, "R6 R3 ctx0 first write");
        expect_out(4, 1,     25, "R11 ctx4 after ignored out");
        expect_out(0, 42,    28, "R4 ctx7 after jump");
        expect_out(1, 1,     29, "R5 ctx8 wrap add");
        expect_out(7, 8,     34, "R8 ctx3 read of owned channel");
        expect_out(2, 9,     41, "R6 ctx0 owner rewrite");
        expect_out(2, 7,     52, "R7 ctx1 retry after wait");
        expect_out(9, 6,     67, "R10 ctx6 after hold release");
        expect_out(5, 12'hB0,73, "R2 R4 R5 ctx2 memory arithmetic");

        @(negedge clk);
        rst = 1'b0; ctx_hold = '0; running = 1;
        while (ncyc < 90) begin
            @(negedge clk);
            case (ncyc)
                16: chk(chan_busy[9] == 1'b1, "R6 busy after claim", chan_busy[9], 1);
                21: chk(chan_busy[2] == 1'b1, "R6 busy ch2", chan_busy[2], 1);
                44: chk(chan_busy[2] == 1'b1, "R9 non-owner release ignored", chan_busy[2], 1);
                51: chk(chan_busy[2] == 1'b0, "R9 owner release", chan_busy[2], 0);
                52: chk(chan_busy[2] == 1'b1, "R7 waiter claims", chan_busy[2], 1);
                54: chk(chan_busy[7] == 1'b0, "R9 release ch7", chan_busy[7], 0);
                60: ctx_hold[5] = 1'b1;
                61: chk(chan_busy[9] == 1'b0, "R10 hold frees", chan_busy[9], 0);
                62: chk(chan_busy[2] == 1'b0, "R9 second release", chan_busy[2], 0);
                default: ;
            endcase
        end
        chk(q.size() == 0, "R6 all writes seen", q.size(), 0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule